// File: doc/BRIEF.md
# I2C EEPROM Command Sequencer

This block is a two-wire bus master for a serial EEPROM. Each command it takes is one coded bus primitive: a START condition, a STOP condition, a one-byte write, a one-byte read that the master acknowledges, or a final one-byte read that the master leaves unacknowledged. It drives the clock line and pulls the data line low through an open-drain enable. It keeps a byte register that holds the byte being shifted and, after a read, the received byte. It reports whether it is busy, the acknowledge level the slave returned after the last write, and an error flag for command codes it does not recognise.

Once any bus primitive has run, the clock keeps toggling at its normal rate with the data line held, until a halt command (code 0000) stops it with the clock high. Commands arrive on a valid/ready port. `cmd_ready` is high only when no primitive is in progress and no read result is waiting. Read results leave on a valid/ready port. `rx_valid` and `rx_data` are held until the consumer raises `rx_ready`, so a slow consumer stalls the command port. Status pins are plain levels.

Top module: `i2cseq_top`

## Requirements
- R1: After reset, `scl_o` is 1, `sda_oe` is 0, `busy`, `error`, `ack_n` and `rx_valid` are 0, and `cmd_ready` is 1.
- R2: A command is taken only on a cycle with `cmd_valid` and `cmd_ready` both high. `cmd_ready` is 0 while `busy` is 1 or while `rx_valid` is 1.
- R3: Code 1001 produces a START: the data line falls while the clock is high.
- R4: Code 0101 produces a STOP: the data line rises while the clock is high.
- R5: Code 0011 sends `cmd_wdata` MSB first in eight clocks, and SDA changes only while SCL is low. On the ninth clock the master releases SDA, and the line level sampled there (0 = acknowledged) is stored in `ack_n`.
- R6: Code 0010 samples eight bits MSB first while the clock is high, then pulls SDA low on the ninth clock. The byte appears on `rx_data` with `rx_valid` = 1.
- R7: Code 0110 reads a byte like code 0010, but leaves SDA released on the ninth clock.
- R8: While `rx_valid` is 1 and `rx_ready` is 0, `rx_valid` stays 1 and `rx_data` does not change. `rx_valid` clears on the cycle after `rx_ready` is taken.
- R9: After any bus primitive ends, SCL keeps toggling with SDA held until a halt command is taken.
- R10: Code 0000 does not set `busy`. The cycle after it is taken, SCL is high and stays high, and `error` is cleared.
- R11: Any other code sets `error`, does not set `busy`, and causes no bus action. The next defined code clears `error`.
- R12: One SCL period is 4*CLK_DIV system clocks, and SCL is high for 2*CLK_DIV of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken |
| cmd_code | input | 4 | Command code |
| cmd_wdata | input | DATA_W | Byte to send with code 0011 |
| rx_valid | output | 1 | Read result available |
| rx_ready | input | 1 | Consumer takes the read result |
| rx_data | output | DATA_W | Received byte |
| scl_o | output | 1 | Serial clock |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| sda_i | input | 1 | Sensed SDA line level |
| busy | output | 1 | Bus primitive in progress |
| ack_n | output | 1 | SDA level at the ninth clock of the last write |
| error | output | 1 | Last command code was undefined |

## Verification
The hardest cases to reach are the boundaries between primitives. A new command can arrive at any quarter of a free-running clock, and the data line must then move to its first value without making a false START or STOP. The bench issues commands with the clock in different phases: straight after another primitive, after a halt with SCL high, and after an undefined code while the clock runs. A decoder watches the bus and reports every START, STOP and nine-bit frame to a scoreboard, so any stray edge while SCL is high shows up as an unexpected item. A slave model drives the read bytes and the write acknowledges, and it changes SDA only while SCL is low.

// File: rtl/i2cseq_pkg.sv
package i2cseq_pkg;
  localparam logic [3:0] CODE_HALT   = 4'b0000;
  localparam logic [3:0] CODE_RDACK  = 4'b0010;
  localparam logic [3:0] CODE_WRITE  = 4'b0011;
  localparam logic [3:0] CODE_STOP   = 4'b0101;
  localparam logic [3:0] CODE_RDLAST = 4'b0110;
  localparam logic [3:0] CODE_START  = 4'b1001;

  // quarter phases of one bit slot, Gray coded; SCL equals bit 0
  localparam logic [1:0] Q0 = 2'b00;
  localparam logic [1:0] Q1 = 2'b01;
  localparam logic [1:0] Q2 = 2'b11;
  localparam logic [1:0] Q3 = 2'b10;

  typedef enum logic [2:0] {
    OP_START, OP_STOP, OP_WRITE, OP_RDACK, OP_RDLAST
  } op_e;
endpackage

// File: rtl/i2cseq_quarter.sv
module i2cseq_quarter #(
  parameter int CLK_DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic       run,
  output logic       tick,
  output logic [1:0] phase
);
  import i2cseq_pkg::*;
  localparam int CW = (CLK_DIV < 2) ? 1 : $clog2(CLK_DIV);
  localparam logic [CW-1:0] LAST = CW'(CLK_DIV - 1);

  logic [CW-1:0] cnt_q;

  function automatic logic [1:0] gray_next(input logic [1:0] p);
    case (p)
      Q0:      return Q1;
      Q1:      return Q2;
      Q2:      return Q3;
      default: return Q0;
    endcase
  endfunction

  assign tick = run && !restart && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      phase <= Q0;
    end else if (restart) begin
      cnt_q <= '0;
      phase <= Q3;
    end else if (run) begin
      if (cnt_q == LAST) begin
        cnt_q <= '0;
        phase <= gray_next(phase);
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  a_r12_single_bit_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && $past(rst_n)) |=> ($countones(phase ^ $past(phase)) == 1));
endmodule

// File: rtl/i2cseq_shreg.sv
module i2cseq_shreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  input  logic         in_bit,
  output logic         msb,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (load)  q <= load_val;
    else if (shift) q <= {q[W-2:0], in_bit};
  end
  assign msb = q[W-1];
endmodule

// File: rtl/i2cseq_top.sv
module i2cseq_top #(
  parameter int CLK_DIV = 4,
  parameter int DATA_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [3:0]        cmd_code,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [DATA_W-1:0] rx_data,
  output logic              scl_o,
  output logic              sda_oe,
  input  logic              sda_i,
  output logic              busy,
  output logic              ack_n,
  output logic              error
);
  import i2cseq_pkg::*;
  localparam int BCW = $clog2(DATA_W + 1);
  localparam logic [BCW-1:0] ACK_SLOT = BCW'(DATA_W);

  logic           tick, lead_q, run_q, hold_q, drv;
  logic [1:0]     phase;
  logic [BCW-1:0] bcnt_q;
  op_e            op_q, dec_op;
  logic           dec_bus, dec_halt, acc, byte_op, last_bit, active, sh_msb, sh_en;

  assign cmd_ready = !busy && !rx_valid;
  assign acc       = cmd_valid && cmd_ready;

  always_comb begin
    dec_bus  = 1'b1;
    dec_halt = 1'b0;
    dec_op   = OP_START;
    case (cmd_code)
      CODE_START:  dec_op = OP_START;
      CODE_STOP:   dec_op = OP_STOP;
      CODE_WRITE:  dec_op = OP_WRITE;
      CODE_RDACK:  dec_op = OP_RDACK;
      CODE_RDLAST: dec_op = OP_RDLAST;
      CODE_HALT:   begin dec_bus = 1'b0; dec_halt = 1'b1; end
      default:     dec_bus = 1'b0;
    endcase
  end

  assign byte_op  = (op_q == OP_WRITE) || (op_q == OP_RDACK) || (op_q == OP_RDLAST);
  assign last_bit = byte_op ? (bcnt_q == ACK_SLOT) : 1'b1;
  assign active   = busy && !lead_q;
  assign sh_en    = tick && active && byte_op && (phase == Q2) && !last_bit;

  i2cseq_quarter #(.CLK_DIV(CLK_DIV)) u_quarter (
    .clk(clk), .rst_n(rst_n), .restart(acc && dec_bus),
    .run(busy || run_q), .tick(tick), .phase(phase)
  );

  i2cseq_shreg #(.W(DATA_W)) u_shreg (
    .clk(clk), .rst_n(rst_n), .load(acc && cmd_code == CODE_WRITE),
    .load_val(cmd_wdata), .shift(sh_en), .in_bit(sda_i),
    .msb(sh_msb), .q(rx_data)
  );

  // data line pull-down; outside an active slot the last level is held
  always_comb begin
    drv = hold_q;
    if (active) begin
      case (op_q)
        OP_START: drv = (phase == Q2) || (phase == Q3);
        OP_STOP:  drv = (phase == Q0) || (phase == Q1);
        OP_WRITE: drv = last_bit ? 1'b0 : !sh_msb;
        OP_RDACK: drv = last_bit;
        default:  drv = 1'b0;
      endcase
    end
  end
  assign sda_oe = drv;
  assign scl_o  = (busy || run_q) ? phase[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; lead_q <= 1'b0; run_q <= 1'b0; hold_q <= 1'b0;
      error <= 1'b0; ack_n <= 1'b0; rx_valid <= 1'b0;
      op_q <= OP_START; bcnt_q <= '0;
    end else begin
      hold_q <= drv;
      if (rx_valid && rx_ready) rx_valid <= 1'b0;
      if (acc) begin
        if (dec_bus) begin
          busy <= 1'b1; lead_q <= 1'b1; op_q <= dec_op;
          bcnt_q <= '0; error <= 1'b0;
        end else if (dec_halt) begin
          run_q <= 1'b0; error <= 1'b0;
        end else begin
          error <= 1'b1;
        end
      end else if (tick && busy) begin
        if (lead_q) begin
          lead_q <= 1'b0;
        end else begin
          if (phase == Q2 && op_q == OP_WRITE && last_bit) ack_n <= sda_i;
          if (phase == Q3) begin
            if (last_bit) begin
              busy  <= 1'b0;
              run_q <= 1'b1;
              if (op_q == OP_RDACK || op_q == OP_RDLAST) rx_valid <= 1'b1;
            end else begin
              bcnt_q <= bcnt_q + 1'b1;
            end
          end
        end
      end
    end
  end

  a_r5_sda_still_while_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && byte_op && scl_o && $past(scl_o)) |-> $stable(sda_oe));
  a_r3_start_fall_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && op_q == OP_START && $rose(sda_oe)) |-> scl_o);
  a_r8_result_held: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));
  a_r10_halt_parks_high: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_code == CODE_HALT) |=> (scl_o && !busy));
  a_r11_bad_code_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !dec_bus && !dec_halt) |=> (error && !busy));
  a_r2_no_take_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && $past(cmd_valid)) |-> $stable(op_q));
endmodule

// File: tb/sim_i2cseq_top.sv
`timescale 1ns/1ps
module sim_i2cseq_top;
  localparam int DIV = 4;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, rx_ready = 1'b0;
  logic [3:0] cmd_code = 4'h0;
  logic [7:0] cmd_wdata = 8'h00;
  logic cmd_ready, rx_valid, scl_o, sda_oe, busy, ack_n, error, sda_i;
  logic [7:0] rx_data;
  logic slave_low = 1'b0;
  int checks = 0, errors = 0;
  bit done = 0;
  int expq[$];
  string reqq[$];
  int smode = 0, srise = 0, nb = 0;
  logic [7:0] sbyte = 8'h00;
  bit sack = 1'b1;
  logic prev_scl = 1'b1, prev_sda = 1'b1;
  logic [8:0] sh = '0;

  always #2.5 clk = ~clk;
  assign sda_i = !(sda_oe || slave_low);

  i2cseq_top #(.CLK_DIV(DIV), .DATA_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_code(cmd_code), .cmd_wdata(cmd_wdata), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_data(rx_data), .scl_o(scl_o), .sda_oe(sda_oe),
    .sda_i(sda_i), .busy(busy), .ack_n(ack_n), .error(error)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic emit(input int v);
    if (expq.size() == 0) chk(0, "R3 R4 R5 unexpected bus event", v, 0);
    else begin
      int e = expq.pop_front();
      string r = reqq.pop_front();
      chk(v == e, r, v, e);
    end
  endtask

  // bus monitor and slave model, sampled mid-cycle
  always @(negedge clk) begin
    logic ln;
    if (!rst_n) begin
      prev_scl = 1'b1; prev_sda = 1'b1; nb = 0; srise = 0; slave_low = 1'b0;
    end else begin
      ln = !(sda_oe || slave_low);
      if (scl_o && prev_scl && prev_sda && !ln) emit(1000);
      if (scl_o && prev_scl && !prev_sda && ln) emit(2000);
      if (!busy) nb = 0;
      else if (scl_o && !prev_scl) begin
        sh = {sh[7:0], ln};
        nb++;
        if (nb == 9) begin emit(int'(sh)); nb = 0; end
      end
      if (!busy) begin srise = 0; slave_low = 1'b0; end
      else begin
        if (scl_o && !prev_scl) srise++;
        if (!scl_o) begin
          if (smode == 1) slave_low = (srise == 8) && sack;
          else if (smode == 2) slave_low = (srise < 8) && !sbyte[7 - srise];
          else slave_low = 1'b0;
        end
      end
      prev_scl = scl_o;
      prev_sda = !(sda_oe || slave_low);
    end
  end

  task automatic send(input logic [3:0] code, input logic [7:0] d);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_code = code; cmd_wdata = d;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (busy) @(negedge clk);
  endtask

  task automatic do_start();
    smode = 0; expq.push_back(1000); reqq.push_back("R3 start");
    send(4'b1001, 8'h00);
  endtask

  task automatic do_stop();
    smode = 0; expq.push_back(2000); reqq.push_back("R4 stop");
    send(4'b0101, 8'h00);
  endtask

  task automatic do_write(input logic [7:0] b, input bit slave_acks);
    smode = 1; sack = slave_acks;
    expq.push_back(int'({b, !slave_acks})); reqq.push_back("R5 write frame");
    send(4'b0011, b);
    chk(ack_n == !slave_acks, "R5 ack_n", ack_n, !slave_acks);
  endtask

  task automatic do_read(input logic [7:0] b, input bit last);
    smode = 2; sbyte = b;
    expq.push_back(int'({b, last}));
    reqq.push_back(last ? "R7 last read frame" : "R6 read frame");
    send(last ? 4'b0110 : 4'b0010, 8'h00);
    chk(rx_valid == 1'b1, "R6 rx_valid", rx_valid, 1);
    chk(rx_data == b, last ? "R7 rx_data" : "R6 rx_data", rx_data, b);
    chk(cmd_ready == 1'b0, "R2 ready low with pending result", cmd_ready, 0);
    repeat (3) @(negedge clk);
    chk(rx_valid && rx_data == b, "R8 result held", rx_data, b);
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
    chk(rx_valid == 1'b0, "R8 rx_valid clears", rx_valid, 0);
    chk(cmd_ready == 1'b1, "R2 ready back", cmd_ready, 1);
    smode = 0;
  endtask

  task automatic measure_period();
    int per = 0, hi = 0;
    logic p;
    p = scl_o; @(negedge clk);
    while (!(scl_o && !p)) begin p = scl_o; @(negedge clk); end
    p = scl_o;
    do begin
      @(negedge clk); per++;
      if (p) hi++;
      if (scl_o && !p) break;
      p = scl_o;
    end while (per < 100);
    chk(per == 4 * DIV, "R12 scl period", per, 4 * DIV);
    chk(hi == 2 * DIV, "R12 scl high time", hi, 2 * DIV);
  endtask

  task automatic count_rises(input int n, output int r);
    logic p;
    r = 0; p = scl_o;
    repeat (n) begin
      @(negedge clk);
      if (scl_o && !p) r++;
      p = scl_o;
    end
  endtask

  initial begin
    int r;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(scl_o == 1'b1, "R1 scl idle", scl_o, 1);
    chk(sda_oe == 1'b0, "R1 sda released", sda_oe, 0);
    chk(busy == 1'b0 && error == 1'b0 && ack_n == 1'b0, "R1 status clear",
        {busy, error, ack_n}, 0);
    chk(cmd_ready == 1'b1 && rx_valid == 1'b0, "R1 ready", {cmd_ready, rx_valid}, 2);

    // undefined code while stopped
    send(4'b0111, 8'h00);
    chk(error == 1'b1, "R11 error set", error, 1);
    count_rises(40, r);
    chk(r == 0 && busy == 1'b0, "R11 no bus action", r, 0);

    do_start();
    chk(error == 1'b0, "R11 error cleared", error, 0);
    measure_period();
    count_rises(40, r);
    chk(r >= 2, "R9 clock keeps running", r, 2);
    do_write(8'hA0, 1'b1);
    do_write(8'h5A, 1'b0);
    do_write(8'h81, 1'b1);
    do_read(8'hC3, 1'b0);
    do_read(8'h00, 1'b0);
    do_read(8'h3C, 1'b1);

    // undefined code while the clock runs
    send(4'b1111, 8'h00);
    chk(error == 1'b1 && busy == 1'b0, "R11 error while running", error, 1);
    count_rises(40, r);
    chk(r >= 2, "R9 running after bad code", r, 2);

    do_stop();
    send(4'b0000, 8'h00);
    chk(busy == 1'b0 && scl_o == 1'b1, "R10 halt", {busy, scl_o}, 1);
    chk(error == 1'b0, "R10 halt clears error", error, 0);
    count_rises(60, r);
    chk(r == 0 && scl_o == 1'b1, "R10 clock parked high", r, 0);

    // restart from a parked clock
    do_start();
    do_read(8'hFF, 1'b1);
    do_stop();
    send(4'b0000, 8'h00);
    repeat (20) @(negedge clk);
    chk(expq.size() == 0, "R3 all bus events seen", expq.size(), 0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule